// File: doc/BRIEF.md
# HDLC Link Status and DMA Request Unit

This unit builds the primary status byte, a secondary status byte, a shared interrupt line and two separate DMA request lines for a byte-oriented HDLC link controller. It takes the control-register-1 write path, the modem inputs for clear-to-send and carrier detect (both active low), level inputs from the FIFOs, event pulses from the serial engines, and a strobe for each CPU read of the receive data register. The FIFOs, the serial bit engines and CRC live elsewhere.

Each direction can run in interrupt mode or in DMA mode. In DMA mode that direction stops driving the shared interrupt and raises its own request line instead. A read of received data always pulls the receive request down at once, in either mode. The unit also applies the receiver and transmitter reset actions to the sticky flags. All outputs are worked out from the next flag values and registered, so any input change shows one clock later, except that the read strobe masks the receive request in the same cycle.

Top module: `hdlc_stat_dreq`

## Requirements
- R1: The control byte is decoded as bit 1 receive interrupt enable, bit 2 transmit interrupt enable, bit 3 receive DMA mode, bit 4 transmit DMA mode, bit 6 receiver reset and bit 7 transmitter reset. A written value takes effect in the same clock as the write. A write with bit 5 set gives a one-cycle pulse on `disc_o` after the next edge.
- R2: `status1_o` bits are: 0 receive data available, 1 secondary status request, 2 always zero, 3 frame detected, 4 clear-to-send lost, 5 transmit underrun, 6 transmit data register available, 7 interrupt. Bit 7 always equals `irq_o`. All outputs are zero after reset, and input changes appear after one clock edge.
- R3: Transmit data available equals `tx_space_i`, forced low while the transmitter reset bit is set or the clear-to-send-lost flag is set.
- R4: The transmit side drives the interrupt only when bit 2 is set, bit 4 is clear, and underrun or transmit data available is set.
- R5: The receive side drives the interrupt only when bit 1 is set, bit 3 is clear, and any of secondary request, receive data available or clear-to-send lost is set.
- R6: `rx_dreq_o` is receive data available gated by bit 3. `tx_dreq_o` is transmit data available gated by bit 4.
- R7: While `rx_rd_i` is high, `rx_dreq_o` is low in that same cycle and also in the cycle after the following edge.
- R8: Clear-to-send lost latches on a rising edge of `cts_n_i`. Underrun latches on a `tx_underrun_i` pulse. Both stay set until a transmitter reset.
- R9: While the receiver reset bit is set, frame detected, receive data available and status2 bits 5:0 read zero, and carrier lost follows the `dcd_n_i` level.
- R10: While the transmitter reset bit is set, underrun and transmit data available read zero, and clear-to-send lost follows the `cts_n_i` level.
- R11: `status2_o` bits 5:0 latch the matching `sr2_set_i` pulses, bit 6 is carrier lost (latched on a rising edge of `dcd_n_i`), and bit 7 is zero. The secondary request is the OR of `status2_o`. Frame detected latches on `flag_det_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cr1_we | input | 1 | Control byte write strobe |
| cr1_wdata | input | 8 | Control byte value |
| cts_n_i | input | 1 | Clear-to-send, active low |
| dcd_n_i | input | 1 | Carrier detect, active low |
| tx_space_i | input | 1 | Transmit FIFO can accept a byte |
| rda_i | input | 1 | Receive FIFO holds a byte |
| tx_underrun_i | input | 1 | Transmit underrun event pulse |
| flag_det_i | input | 1 | Flag sequence detected pulse |
| sr2_set_i | input | S2_W | Secondary status event pulses |
| rx_rd_i | input | 1 | CPU read of the receive data register |
| status1_o | output | 8 | Primary status byte |
| status2_o | output | 8 | Secondary status byte |
| irq_o | output | 1 | Shared interrupt request |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |
| disc_o | output | 1 | Discard-current-frame pulse |

## Verification
The hardest cases to reach involve the sticky modem flags. A receiver or transmitter reset held while the modem line is inactive has to reload the flag from the level rather than clear it. A read strobe that lands while receive data is present must hold the request off across two cycles. Directed sequences first walk all sixteen settings of the enable and DMA-mode bits against each status source, clearing the sticky flags with a reset write before each source. A long random run then mixes rare reset writes with modem-line toggles and read strobes, so that these overlaps occur many times.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  localparam int CR_RXIE  = 1;
  localparam int CR_TXIE  = 2;
  localparam int CR_RXDMA = 3;
  localparam int CR_TXDMA = 4;
  localparam int CR_DISC  = 5;
  localparam int CR_RXRST = 6;
  localparam int CR_TXRST = 7;

  localparam int ST_RDA  = 0;
  localparam int ST_S2RQ = 1;
  localparam int ST_FD   = 3;
  localparam int ST_CTS  = 4;
  localparam int ST_TU   = 5;
  localparam int ST_TDRA = 6;
  localparam int ST_IRQ  = 7;

  localparam int S2_CD = 6;

  typedef struct packed {
    logic fd;
    logic cd;
    logic cts;
    logic tu;
  } sticky_t;
endpackage

// File: rtl/hdlc_cr1_reg.sv
module hdlc_cr1_reg
  import hdlc_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] cr_eff,
  output logic [7:0] cr_q,
  output logic       disc_q
);
  assign cr_eff = we ? wdata : cr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q   <= '0;
      disc_q <= 1'b0;
    end else begin
      cr_q   <= cr_eff;
      disc_q <= we & wdata[CR_DISC];
    end
  end
endmodule

// File: rtl/hdlc_sticky_flags.sv
module hdlc_sticky_flags
  import hdlc_stat_pkg::*;
#(
  parameter int S2_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_rst,
  input  logic            tx_rst,
  input  logic            cts_n_i,
  input  logic            dcd_n_i,
  input  logic            underrun,
  input  logic            flag_det,
  input  logic [S2_W-1:0] s2_set,
  output sticky_t         fl_nxt,
  output logic [S2_W-1:0] s2_nxt
);
  sticky_t         fl_q;
  logic [S2_W-1:0] s2_q;
  logic            cts_in_q, dcd_in_q;
  logic            cts_rise, dcd_rise;

  assign cts_rise = cts_n_i & ~cts_in_q;
  assign dcd_rise = dcd_n_i & ~dcd_in_q;

  always_comb begin
    fl_nxt.fd  = rx_rst ? 1'b0    : (fl_q.fd | flag_det);
    fl_nxt.cd  = rx_rst ? dcd_n_i : (fl_q.cd | dcd_rise);
    fl_nxt.cts = tx_rst ? cts_n_i : (fl_q.cts | cts_rise);
    fl_nxt.tu  = tx_rst ? 1'b0    : (fl_q.tu | underrun);
  end

  genvar gi;
  generate
    for (gi = 0; gi < S2_W; gi++) begin : g_s2
      assign s2_nxt[gi] = rx_rst ? 1'b0 : (s2_q[gi] | s2_set[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q     <= '0;
      s2_q     <= '0;
      cts_in_q <= 1'b0;
      dcd_in_q <= 1'b0;
    end else begin
      fl_q     <= fl_nxt;
      s2_q     <= s2_nxt;
      cts_in_q <= cts_n_i;
      dcd_in_q <= dcd_n_i;
    end
  end
endmodule

// File: rtl/hdlc_req_eval.sv
module hdlc_req_eval
  import hdlc_stat_pkg::*;
#(
  parameter int S2_W = 6
) (
  input  logic [7:0]      cr,
  input  sticky_t         fl,
  input  logic [S2_W-1:0] s2,
  input  logic            rda_i,
  input  logic            tx_space_i,
  input  logic            rd_i,
  output logic [7:0]      st1,
  output logic [7:0]      st2,
  output logic            irq,
  output logic            rx_req,
  output logic            tx_req
);
  logic rda, tdra, s2rq, irq_tx, irq_rx;

  always_comb begin
    st2            = '0;
    st2[S2_W-1:0]  = s2;
    st2[S2_CD]     = fl.cd;
  end

  assign rda    = rda_i & ~cr[CR_RXRST];
  assign tdra   = tx_space_i & ~cr[CR_TXRST] & ~fl.cts;
  assign s2rq   = |st2;
  assign irq_tx = cr[CR_TXIE] & ~cr[CR_TXDMA] & (fl.tu | tdra);
  assign irq_rx = cr[CR_RXIE] & ~cr[CR_RXDMA] & (s2rq | rda | fl.cts);
  assign irq    = irq_tx | irq_rx;
  assign rx_req = rda & cr[CR_RXDMA] & ~rd_i;
  assign tx_req = tdra & cr[CR_TXDMA];

  always_comb begin
    st1          = '0;
    st1[ST_RDA]  = rda;
    st1[ST_S2RQ] = s2rq;
    st1[ST_FD]   = fl.fd;
    st1[ST_CTS]  = fl.cts;
    st1[ST_TU]   = fl.tu;
    st1[ST_TDRA] = tdra;
    st1[ST_IRQ]  = irq;
  end
endmodule

// File: rtl/hdlc_stat_dreq.sv
module hdlc_stat_dreq
  import hdlc_stat_pkg::*;
#(
  parameter int S2_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cr1_we,
  input  logic [7:0]      cr1_wdata,
  input  logic            cts_n_i,
  input  logic            dcd_n_i,
  input  logic            tx_space_i,
  input  logic            rda_i,
  input  logic            tx_underrun_i,
  input  logic            flag_det_i,
  input  logic [S2_W-1:0] sr2_set_i,
  input  logic            rx_rd_i,
  output logic [7:0]      status1_o,
  output logic [7:0]      status2_o,
  output logic            irq_o,
  output logic            rx_dreq_o,
  output logic            tx_dreq_o,
  output logic            disc_o
);
  logic [7:0]      cr_eff, cr1_q;
  sticky_t         fl_nxt;
  logic [S2_W-1:0] s2_nxt;
  logic [7:0]      st1_n, st2_n;
  logic            irq_n, rxr_n, txr_n;
  logic            rxr_q;

  hdlc_cr1_reg u_cr (
    .clk(clk), .rst_n(rst_n), .we(cr1_we), .wdata(cr1_wdata),
    .cr_eff(cr_eff), .cr_q(cr1_q), .disc_q(disc_o)
  );

  hdlc_sticky_flags #(.S2_W(S2_W)) u_fl (
    .clk(clk), .rst_n(rst_n),
    .rx_rst(cr_eff[CR_RXRST]), .tx_rst(cr_eff[CR_TXRST]),
    .cts_n_i(cts_n_i), .dcd_n_i(dcd_n_i),
    .underrun(tx_underrun_i), .flag_det(flag_det_i), .s2_set(sr2_set_i),
    .fl_nxt(fl_nxt), .s2_nxt(s2_nxt)
  );

  hdlc_req_eval #(.S2_W(S2_W)) u_ev (
    .cr(cr_eff), .fl(fl_nxt), .s2(s2_nxt),
    .rda_i(rda_i), .tx_space_i(tx_space_i), .rd_i(rx_rd_i),
    .st1(st1_n), .st2(st2_n), .irq(irq_n), .rx_req(rxr_n), .tx_req(txr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status1_o <= '0;
      status2_o <= '0;
      irq_o     <= 1'b0;
      rxr_q     <= 1'b0;
      tx_dreq_o <= 1'b0;
    end else begin
      status1_o <= st1_n;
      status2_o <= st2_n;
      irq_o     <= irq_n;
      rxr_q     <= rxr_n;
      tx_dreq_o <= txr_n;
    end
  end

  assign rx_dreq_o = rxr_q & ~rx_rd_i;
endmodule

// File: rtl/hdlc_stat_dreq_chk.sv
module hdlc_stat_dreq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cr1_we,
  input logic [7:0] cr1_q,
  input logic       tx_underrun_i,
  input logic       rx_rd_i,
  input logic [7:0] status1_o,
  input logic       irq_o,
  input logic       rx_dreq_o
);
  assert_irq_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status1_o[7] == irq_o);
  assert_tdra_cts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status1_o[4] |-> !status1_o[6]);
  // R4 and R5: both directions in DMA mode leave the interrupt quiet
  assert_dma_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cr1_q[3] && cr1_q[4]) |-> !irq_o);
  assert_rxreq_rda_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq_o |-> status1_o[0]);
  assert_rd_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_i |-> !rx_dreq_o);
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_i |=> !rx_dreq_o);
  assert_tu_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underrun_i && !cr1_we && !cr1_q[7]) |=> status1_o[5]);
  assert_rx_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cr1_q[6] |-> (!status1_o[3] && !status1_o[0]));
  assert_tx_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cr1_q[7] |-> (!status1_o[5] && !status1_o[6]));
endmodule

bind hdlc_stat_dreq hdlc_stat_dreq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cr1_we(cr1_we), .cr1_q(cr1_q),
  .tx_underrun_i(tx_underrun_i), .rx_rd_i(rx_rd_i),
  .status1_o(status1_o), .irq_o(irq_o), .rx_dreq_o(rx_dreq_o)
);

// File: tb/tb_hdlc_stat_dreq.sv
`timescale 1ns/1ps
module tb_hdlc_stat_dreq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cr1_we = 0, cts_n_i = 0, dcd_n_i = 0, tx_space_i = 0, rda_i = 0;
  logic tx_underrun_i = 0, flag_det_i = 0, rx_rd_i = 0;
  logic [7:0] cr1_wdata = 0;
  logic [5:0] sr2_set_i = 0;
  logic [7:0] status1_o, status2_o;
  logic irq_o, rx_dreq_o, tx_dreq_o, disc_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] m_cr = 0;
  logic [5:0] m_s2 = 0;
  logic m_fd = 0, m_cd = 0, m_cts = 0, m_tu = 0, m_ctsq = 0, m_dcdq = 0;

  always #2.5 clk = ~clk;

  hdlc_stat_dreq dut (
    .clk(clk), .rst_n(rst_n), .cr1_we(cr1_we), .cr1_wdata(cr1_wdata),
    .cts_n_i(cts_n_i), .dcd_n_i(dcd_n_i), .tx_space_i(tx_space_i), .rda_i(rda_i),
    .tx_underrun_i(tx_underrun_i), .flag_det_i(flag_det_i), .sr2_set_i(sr2_set_i),
    .rx_rd_i(rx_rd_i), .status1_o(status1_o), .status2_o(status2_o), .irq_o(irq_o),
    .rx_dreq_o(rx_dreq_o), .tx_dreq_o(tx_dreq_o), .disc_o(disc_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // one cycle: drive, model the requirements, compare after the edge
  task automatic step(input logic we, input logic [7:0] wd, input logic cts, input logic dcd,
                      input logic sp, input logic rda, input logic un, input logic fdt,
                      input logic [5:0] s2s, input logic rd);
    logic [7:0] cr, e1, e2;
    logic rr, tr, fd, cd, ct, tu, rdaf, s2rq, tdra, irq;
    logic [5:0] s2;
    cr1_we = we; cr1_wdata = wd; cts_n_i = cts; dcd_n_i = dcd; tx_space_i = sp;
    rda_i = rda; tx_underrun_i = un; flag_det_i = fdt; sr2_set_i = s2s; rx_rd_i = rd;
    cr = we ? wd : m_cr; rr = cr[6]; tr = cr[7];
    fd = rr ? 1'b0 : (m_fd | fdt);
    s2 = rr ? 6'd0 : (m_s2 | s2s);
    cd = rr ? dcd : (m_cd | (dcd & ~m_dcdq));
    ct = tr ? cts : (m_cts | (cts & ~m_ctsq));
    tu = tr ? 1'b0 : (m_tu | un);
    rdaf = rda & ~rr;
    s2rq = (|s2) | cd;
    tdra = sp & ~tr & ~ct;
    irq = (cr[2] & ~cr[4] & (tu | tdra)) | (cr[1] & ~cr[3] & (s2rq | rdaf | ct));
    e1 = {irq, tdra, tu, ct, fd, 1'b0, s2rq, rdaf};
    e2 = {1'b0, cd, s2};
    m_cr = cr; m_fd = fd; m_s2 = s2; m_cd = cd; m_cts = ct; m_tu = tu;
    m_ctsq = cts; m_dcdq = dcd;
    @(posedge clk); #1;
    chk("R2 status1 byte", status1_o, e1);
    chk("R3 tdra", {7'd0, status1_o[6]}, {7'd0, tdra});
    chk("R8 R10 cts/tu", {6'd0, status1_o[5:4]}, {6'd0, tu, ct});
    chk("R9 fd/rda", {6'd0, status1_o[3], status1_o[0]}, {6'd0, fd, rdaf});
    chk("R11 status2", status2_o, e2);
    chk("R4 R5 irq", {7'd0, irq_o}, {7'd0, irq});
    chk("R6 R7 rx_dreq", {7'd0, rx_dreq_o}, {7'd0, rdaf & cr[3] & ~rd});
    chk("R6 tx_dreq", {7'd0, tx_dreq_o}, {7'd0, tdra & cr[4]});
    chk("R1 disc", {7'd0, disc_o}, {7'd0, we & wd[5]});
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    chk("R2 reset status1", status1_o, 8'h00);
    chk("R2 reset status2", status2_o, 8'h00);
    chk("R2 reset lines", {4'd0, irq_o, rx_dreq_o, tx_dreq_o, disc_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R5 R6: every enable / DMA-mode setting against each source
    for (int m = 0; m < 16; m++) begin
      logic [7:0] c;
      c = {3'b000, m[3:0], 1'b0};
      step(1, 8'hC0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1, c, 0, 0, 1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
      step(1, 8'hC0 | c, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1, c, 0, 0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 6'h04, 0);
      step(1, 8'hC0 | c, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1, c, 1, 0, 1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step(1, c, 0, 1, 0, 0, 0, 1, 0, 0);
    end
    // R9: receiver reset held with carrier inactive reloads carrier lost
    step(1, 8'h40, 0, 1, 0, 1, 0, 1, 6'h3F, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R10: transmitter reset held with clear-to-send inactive
    step(1, 8'h80, 1, 0, 1, 0, 1, 0, 0, 0);
    step(1, 8'h14, 1, 0, 1, 0, 0, 0, 0, 0);
    // R1: discontinue pulse
    step(1, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 6000; i++) begin
      logic we;
      logic [7:0] wd;
      we = ($urandom % 12) == 0;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[7:6] = 2'b00;
      step(we, wd, ($urandom % 8) == 0 ? ~cts_n_i : cts_n_i,
           ($urandom % 10) == 0 ? ~dcd_n_i : dcd_n_i,
           $urandom % 2, $urandom % 2, ($urandom % 16) == 0, ($urandom % 16) == 0,
           (($urandom % 16) == 0) ? 6'($urandom) : 6'd0, ($urandom % 4) == 0);
    end
    summary();
  end
endmodule